// File: doc/BRIEF.md
# SPI Status Byte Command Gate

This block is the serial front end of a voice-recording controller. It acts as an SPI slave in mode 0, MSB first. While chip-select is low it returns one status byte on MISO for each byte it receives on MOSI. The only exception is when the core reports that a data-read command is active; in that case the core's read byte goes out at each byte boundary in place of the status byte. Received bytes are passed to the command core as a one-cycle strobe, together with the byte value and a flag marking the opcode byte of the frame.

The block holds the device status flags: power-down, data buffer ready, interrupt pending, recording memory full, macro busy, command buffer full and command busy. Event inputs and decoded commands set and clear them. While powered down, the block passes only status-read, interrupt-read and power-up frames to the core. Any other frame is dropped without a trace, and MISO is released to high impedance.

Commands change the flags when chip-select rises at the end of the frame. The status returned during a frame therefore shows the state from before that command.

Top module: `spi_status_gate`

## Requirements
- R1: After reset the status byte is 0x80 (power-down set, every other flag clear), `misoOe` is low and no command strobe is issued.
- R2: The status byte holds, from bit 7 down to bit 0: power-down, buffer ready, interrupt, memory full, a reserved bit that always reads 0, macro busy, command-buffer full, command busy.
- R3: SPI mode 0, MSB first. The clock idles low, MOSI is sampled on the rising SCLK edge and MISO changes on the falling edge. The current status byte is captured when chip-select falls, and again at the falling SCLK edge that follows the eighth rising edge of each byte. The bit counter returns to zero whenever chip-select is high.
- R4: If `rdActive` is high at a byte-boundary reload, `rdByte` is captured for shifting instead of the status byte. The byte captured when chip-select falls is always the status byte.
- R5: One clock after the clock edge that samples the eighth rising SCLK edge of a byte, an accepted byte raises `cmdValid` for exactly one cycle. `cmdByte` then holds the byte, and `cmdFirst` is high only for the first byte of the frame.
- R6: While power-down is set, a frame whose first byte is not 0x40 (status-read), 0x46 (interrupt-read) or 0x10 (power-up) produces no `cmdValid` for any of its bytes. It changes no flag, and it sets no interrupt.
- R7: `misoOe` is high only while chip-select is low and power-down is clear.
- R8: The buffer-ready bit reads 0 while power-down is set. Otherwise it shows `rdyIn` as sampled on the previous clock.
- R9: The interrupt bit is set one clock after `intEvent`. It is cleared only when chip-select rises at the end of an accepted frame whose opcode is 0x46. If both happen on the same clock, the set wins.
- R10: The memory-full bit is set one clock after `recFull`. It is cleared only when chip-select rises at the end of an accepted frame whose opcode is 0x26, 0x28 or 0x2A. If both happen on the same clock, the set wins.
- R11: Power-down is cleared when chip-select rises at the end of an accepted 0x10 frame, and set when it rises at the end of an accepted 0x12 frame. It changes at no other time.
- R12: The macro-busy, command-buffer-full and command-busy bits show `vmBusyIn`, `cbufFullIn` and `cmdBusyIn` one clock late.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than SCLK |
| rstN | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | SPI clock, already synchronised to clk |
| csN | input | 1 | Active-low chip-select, already synchronised to clk |
| mosi | input | 1 | Serial data from the host |
| miso | output | 1 | Serial data to the host |
| misoOe | output | 1 | MISO drive enable; low means high impedance |
| rdActive | input | 1 | Core has a data-read command running |
| rdByte | input | 8 | Next read byte from the core |
| intEvent | input | 1 | Interrupt source pulse |
| recFull | input | 1 | A recording filled the memory |
| rdyIn | input | 1 | Ready/busy level from the core |
| vmBusyIn | input | 1 | Macro engine busy |
| cbufFullIn | input | 1 | Command buffer full |
| cmdBusyIn | input | 1 | Command engine busy |
| cmdValid | output | 1 | Accepted byte strobe to the core |
| cmdByte | output | 8 | Accepted byte value |
| cmdFirst | output | 1 | Strobed byte is the opcode of its frame |
| statusByte | output | 8 | Current status byte |

## Verification
The bench targets these corner cases:
- Erase and power-down frames sent while powered down. A gate that looked only at the opcode would clear memory-full or strobe the core here.
- An interrupt-read sent while powered down. It must still clear the interrupt, so a gate that was too strict would leave the flag stuck.
- A data-read that begins at the second byte of a frame. A reload placed one SCLK edge out of step would shift out a rotated byte, or repeat the status byte.
- The order of flag updates against the status byte returned in the same frame. A design that applied commands at opcode time, rather than at the end of the frame, would return the already-cleared flags on MISO.

// File: rtl/spi_stat_pkg.sv
package spi_stat_pkg;

  localparam int BYTE_W = 8;
  localparam int CNT_W  = $clog2(BYTE_W);

  localparam logic [BYTE_W-1:0] OP_RD_STATUS = 8'h40;
  localparam logic [BYTE_W-1:0] OP_RD_INT    = 8'h46;
  localparam logic [BYTE_W-1:0] OP_PWR_UP    = 8'h10;
  localparam logic [BYTE_W-1:0] OP_PWR_DN    = 8'h12;
  localparam logic [BYTE_W-1:0] OP_ERASE_MSG = 8'h26;
  localparam logic [BYTE_W-1:0] OP_ERASE_MEM = 8'h28;
  localparam logic [BYTE_W-1:0] OP_ERASE_ALL = 8'h2A;

  // status bit positions, read by the host
  localparam int BIT_PD    = 7;
  localparam int BIT_RDY   = 6;
  localparam int BIT_INT   = 5;
  localparam int BIT_RMFUL = 4;
  localparam int BIT_VM    = 2;
  localparam int BIT_CBUF  = 1;
  localparam int BIT_CMD   = 0;

  // level flags copied from the core, LSB first: command busy, cbuf full, macro busy
  localparam int NUM_FOLLOW = 3;

  typedef struct packed {
    logic loadStatus;
    logic reloadByte;
    logic shiftOut;
    logic shiftIn;
    logic clrPd;
    logic setPd;
    logic clrInt;
    logic clrRm;
  } ctrlStrb_t;

endpackage

// File: rtl/spi_stat_ctrl.sv
module spi_stat_ctrl
  import spi_stat_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclk,
  input  logic              csN,
  input  logic              pdFlag,
  input  logic [BYTE_W-1:0] rxNext,
  output ctrlStrb_t         strb,
  output logic              byteValid,
  output logic [BYTE_W-1:0] byteData,
  output logic              byteFirst
);

  logic              sclkQ;
  logic              csNQ;
  logic [CNT_W-1:0]  bitCnt;
  logic              haveOp;
  logic              passQ;
  logic [BYTE_W-1:0] opcode;

  logic sclkRise, sclkFall, csFall, csRise;
  logic byteEnd, acceptNow, frameDone, eraseOp;

  function automatic logic allowedInPd(input logic [BYTE_W-1:0] op);
    return (op == OP_RD_STATUS) || (op == OP_RD_INT) || (op == OP_PWR_UP);
  endfunction

  assign sclkRise  = sclk && !sclkQ && !csN;
  assign sclkFall  = !sclk && sclkQ && !csN;
  assign csFall    = !csN && csNQ;
  assign csRise    = csN && !csNQ;
  assign byteEnd   = sclkRise && (bitCnt == CNT_W'(BYTE_W - 1));
  assign acceptNow = haveOp ? passQ : (!pdFlag || allowedInPd(rxNext));
  assign frameDone = csRise && haveOp && passQ;
  assign eraseOp   = (opcode == OP_ERASE_MSG) || (opcode == OP_ERASE_MEM) ||
                     (opcode == OP_ERASE_ALL);

  always_comb begin
    strb            = '0;
    strb.loadStatus = csFall;
    strb.reloadByte = sclkFall && (bitCnt == '0);
    strb.shiftOut   = sclkFall && (bitCnt != '0);
    strb.shiftIn    = sclkRise;
    strb.clrPd      = frameDone && (opcode == OP_PWR_UP);
    strb.setPd      = frameDone && (opcode == OP_PWR_DN);
    strb.clrInt     = frameDone && (opcode == OP_RD_INT);
    strb.clrRm      = frameDone && eraseOp;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclkQ     <= 1'b0;
      csNQ      <= 1'b1;
      bitCnt    <= '0;
      haveOp    <= 1'b0;
      passQ     <= 1'b0;
      opcode    <= '0;
      byteValid <= 1'b0;
      byteData  <= '0;
      byteFirst <= 1'b0;
    end else begin
      sclkQ     <= sclk;
      csNQ      <= csN;
      byteValid <= byteEnd && acceptNow;
      if (byteEnd) begin
        byteData  <= rxNext;
        byteFirst <= !haveOp;
      end
      if (csN) begin
        bitCnt <= '0;
        haveOp <= 1'b0;
      end else begin
        if (sclkRise) bitCnt <= bitCnt + 1'b1;
        if (byteEnd && !haveOp) begin
          haveOp <= 1'b1;
          opcode <= rxNext;
          passQ  <= acceptNow;
        end
      end
    end
  end

  assert_valid_pulse_R5 : assert property (@(posedge clk) disable iff (!rstN)
    byteValid |=> !byteValid);

  assert_pd_filter_R6 : assert property (@(posedge clk) disable iff (!rstN)
    (byteValid && byteFirst && $past(pdFlag)) |-> allowedInPd(byteData));

endmodule

// File: rtl/spi_stat_dp.sv
module spi_stat_dp
  import spi_stat_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrb_t         strb,
  input  logic              mosi,
  input  logic              rdActive,
  input  logic [BYTE_W-1:0] rdByte,
  input  logic              intEvent,
  input  logic              recFull,
  input  logic              rdyIn,
  input  logic              vmBusyIn,
  input  logic              cbufFullIn,
  input  logic              cmdBusyIn,
  output logic [BYTE_W-1:0] rxNext,
  output logic [BYTE_W-1:0] statusByte,
  output logic              txBit,
  output logic              pdFlag
);

  logic [BYTE_W-1:0]     rxShift;
  logic [BYTE_W-1:0]     txShift;
  logic                  intFlag;
  logic                  rmFlag;
  logic                  rdyQ;
  logic [NUM_FOLLOW-1:0] followIn;
  logic [NUM_FOLLOW-1:0] followQ;

  assign rxNext   = {rxShift[BYTE_W-2:0], mosi};
  assign txBit    = txShift[BYTE_W-1];
  assign followIn = {vmBusyIn, cbufFullIn, cmdBusyIn};

  for (genvar g = 0; g < NUM_FOLLOW; g++) begin : g_follow
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) followQ[g] <= 1'b0;
      else       followQ[g] <= followIn[g];
    end
  end

  always_comb begin
    statusByte            = '0;
    statusByte[BIT_PD]    = pdFlag;
    statusByte[BIT_RDY]   = rdyQ && !pdFlag;
    statusByte[BIT_INT]   = intFlag;
    statusByte[BIT_RMFUL] = rmFlag;
    statusByte[BIT_VM]    = followQ[2];
    statusByte[BIT_CBUF]  = followQ[1];
    statusByte[BIT_CMD]   = followQ[0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxShift <= '0;
      txShift <= '0;
      pdFlag  <= 1'b1;
      intFlag <= 1'b0;
      rmFlag  <= 1'b0;
      rdyQ    <= 1'b0;
    end else begin
      rdyQ <= rdyIn;
      if (strb.shiftIn) rxShift <= rxNext;
      if (strb.loadStatus)      txShift <= statusByte;
      else if (strb.reloadByte) txShift <= rdActive ? rdByte : statusByte;
      else if (strb.shiftOut)   txShift <= {txShift[BYTE_W-2:0], 1'b0};
      if (strb.setPd)      pdFlag <= 1'b1;
      else if (strb.clrPd) pdFlag <= 1'b0;
      if (intEvent)         intFlag <= 1'b1;
      else if (strb.clrInt) intFlag <= 1'b0;
      if (recFull)         rmFlag <= 1'b1;
      else if (strb.clrRm) rmFlag <= 1'b0;
    end
  end

  assert_int_set_R9 : assert property (@(posedge clk) disable iff (!rstN)
    intEvent |=> statusByte[BIT_INT]);

  assert_rm_set_R10 : assert property (@(posedge clk) disable iff (!rstN)
    recFull |=> statusByte[BIT_RMFUL]);

  assert_pd_only_cmd_R11 : assert property (@(posedge clk) disable iff (!rstN)
    (pdFlag != $past(pdFlag)) |-> $past(strb.setPd || strb.clrPd));

endmodule

// File: rtl/spi_status_gate.sv
module spi_status_gate
  import spi_stat_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclk,
  input  logic              csN,
  input  logic              mosi,
  output logic              miso,
  output logic              misoOe,
  input  logic              rdActive,
  input  logic [BYTE_W-1:0] rdByte,
  input  logic              intEvent,
  input  logic              recFull,
  input  logic              rdyIn,
  input  logic              vmBusyIn,
  input  logic              cbufFullIn,
  input  logic              cmdBusyIn,
  output logic              cmdValid,
  output logic [BYTE_W-1:0] cmdByte,
  output logic              cmdFirst,
  output logic [BYTE_W-1:0] statusByte
);

  ctrlStrb_t         strb;
  logic              pdFlag;
  logic              txBit;
  logic [BYTE_W-1:0] rxNext;

  spi_stat_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .sclk      (sclk),
    .csN       (csN),
    .pdFlag    (pdFlag),
    .rxNext    (rxNext),
    .strb      (strb),
    .byteValid (cmdValid),
    .byteData  (cmdByte),
    .byteFirst (cmdFirst)
  );

  spi_stat_dp u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .mosi       (mosi),
    .rdActive   (rdActive),
    .rdByte     (rdByte),
    .intEvent   (intEvent),
    .recFull    (recFull),
    .rdyIn      (rdyIn),
    .vmBusyIn   (vmBusyIn),
    .cbufFullIn (cbufFullIn),
    .cmdBusyIn  (cmdBusyIn),
    .rxNext     (rxNext),
    .statusByte (statusByte),
    .txBit      (txBit),
    .pdFlag     (pdFlag)
  );

  assign miso   = txBit;
  assign misoOe = !csN && !pdFlag;

  assert_cmd_at_end_R11 : assert property (@(posedge clk) disable iff (!rstN)
    (strb.clrPd || strb.setPd || strb.clrInt || strb.clrRm) |-> (csN && !$past(csN)));

  assert_oe_pd_R7 : assert property (@(posedge clk) disable iff (!rstN)
    misoOe |-> !statusByte[BIT_PD]);

endmodule

// File: tb/spi_status_gate_test.sv
module spi_status_gate_test;

  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclk = 1'b0, csN = 1'b1, mosi = 1'b0;
  logic rdActive = 1'b0;
  logic [7:0] rdByte = 8'h00;
  logic intEvent = 1'b0, recFull = 1'b0, rdyIn = 1'b0;
  logic vmBusyIn = 1'b0, cbufFullIn = 1'b0, cmdBusyIn = 1'b0;
  logic miso, misoOe, cmdValid, cmdFirst;
  logic [7:0] cmdByte, statusByte;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_status_gate uut (
    .clk(clk), .rstN(rstN), .sclk(sclk), .csN(csN), .mosi(mosi),
    .miso(miso), .misoOe(misoOe), .rdActive(rdActive), .rdByte(rdByte),
    .intEvent(intEvent), .recFull(recFull), .rdyIn(rdyIn),
    .vmBusyIn(vmBusyIn), .cbufFullIn(cbufFullIn), .cmdBusyIn(cmdBusyIn),
    .cmdValid(cmdValid), .cmdByte(cmdByte), .cmdFirst(cmdFirst),
    .statusByte(statusByte)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // behavioural reference model
  int mPd, mInt, mRm, mRdy, mVm, mCb, mCmd;
  int mPs, mPc, mBits, mRx, mTx, mHave, mOp, mPass, mBv, mBd, mBf;

  function automatic int mStat();
    return (mPd << 7) | ((mRdy & (1 - mPd)) << 6) | (mInt << 5) | (mRm << 4) |
           (mVm << 2) | (mCb << 1) | mCmd;
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      mPd = 1; mInt = 0; mRm = 0; mRdy = 0; mVm = 0; mCb = 0; mCmd = 0;
      mPs = 0; mPc = 1; mBits = 0; mRx = 0; mTx = 0; mHave = 0; mOp = 0;
      mPass = 0; mBv = 0; mBd = 0; mBf = 0;
    end else begin
      int st, nPd, nInt, nRm, rx;
      bit rise, fall, cfall, crise, endOk, ok;
      rise  = sclk && !mPs && !csN;
      fall  = !sclk && mPs && !csN;
      cfall = !csN && mPc;
      crise = csN && !mPc;
      st    = mStat();
      endOk = crise && mHave && mPass;
      nPd = mPd;
      if (endOk && mOp == 'h10) nPd = 0;
      if (endOk && mOp == 'h12) nPd = 1;
      nInt = intEvent ? 1 : ((endOk && mOp == 'h46) ? 0 : mInt);
      nRm  = recFull ? 1 :
             ((endOk && (mOp == 'h26 || mOp == 'h28 || mOp == 'h2A)) ? 0 : mRm);
      if (cfall) mTx = st;
      else if (fall) mTx = (mBits == 0) ? (rdActive ? int'(rdByte) : st) : ((mTx << 1) & 255);
      mBv = 0;
      if (rise) begin
        rx = ((mRx << 1) | int'(mosi)) & 255;
        if (mBits == 7) begin
          ok = mHave ? (mPass != 0) : (mPd == 0 || rx == 'h40 || rx == 'h46 || rx == 'h10);
          mBv = ok; mBd = rx; mBf = !mHave;
          if (!mHave) begin mOp = rx; mPass = ok; mHave = 1; end
        end
        mRx = rx;
        mBits = (mBits + 1) % 8;
      end
      if (csN) begin mBits = 0; mHave = 0; end
      mPd = nPd; mInt = nInt; mRm = nRm;
      mRdy = rdyIn; mVm = vmBusyIn; mCb = cbufFullIn; mCmd = cmdBusyIn;
      mPs = sclk; mPc = csN;
    end
  end

  logic [8:0] bvQ[$];

  // per-clock comparison, a quarter period after the edge
  always @(posedge clk) begin
    #(CLK_PERIOD/4);
    if (rstN && !finished) begin
      chk("R2 status vs model", int'(statusByte), mStat());
      chk("R5 cmdValid vs model", int'(cmdValid), mBv);
      if (mBv != 0) begin
        chk("R5 cmdByte vs model", int'(cmdByte), mBd);
        chk("R5 cmdFirst vs model", int'(cmdFirst), mBf);
      end
      chk("R7 misoOe vs model", int'(misoOe), int'(!csN && mPd == 0));
      if (misoOe) chk("R3 miso vs model", int'(miso), (mTx >> 7) & 1);
      if (cmdValid) bvQ.push_back({cmdFirst, cmdByte});
    end
  end

  logic [7:0] rxb[4];
  int oeSeen;

  task automatic xfer(input int n, input logic [7:0] b0, input logic [7:0] b1,
                      input logic [7:0] b2);
    logic [7:0] tx[4];
    tx[0] = b0; tx[1] = b1; tx[2] = b2; tx[3] = 8'h00;
    oeSeen = 0;
    bvQ.delete();
    @(negedge clk); csN = 1'b0;
    for (int i = 0; i < n; i++) begin
      for (int b = 7; b >= 0; b--) begin
        repeat (2) @(negedge clk);
        mosi = tx[i][b];
        rxb[i][b] = miso;
        if (misoOe) oeSeen++;
        repeat (2) @(negedge clk); sclk = 1'b1;
        repeat (2) @(negedge clk); sclk = 1'b0;
      end
    end
    repeat (2) @(negedge clk); csN = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic pulse(input int which);
    @(negedge clk);
    if (which == 0) intEvent = 1'b1; else recFull = 1'b1;
    @(negedge clk);
    intEvent = 1'b0; recFull = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog R5 act=hung exp=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 reset status", int'(statusByte), 'h80);
    chk("R1 reset misoOe", int'(misoOe), 0);
    chk("R1 reset cmdValid", int'(cmdValid), 0);

    rdyIn = 1'b1; repeat (2) @(negedge clk);
    chk("R8 rdy masked in PD", int'(statusByte), 'h80);

    xfer(1, 8'h12, 8'h00, 8'h00);
    chk("R6 PD drop count", bvQ.size(), 0);
    chk("R7 no drive in PD", oeSeen, 0);

    xfer(1, 8'h10, 8'h00, 8'h00);
    chk("R6 power-up accepted", bvQ.size(), 1);
    chk("R11 power-up clears PD", int'(statusByte), 'h40);

    vmBusyIn = 1'b1; cbufFullIn = 1'b1; cmdBusyIn = 1'b1;
    @(negedge clk);
    chk("R12 followers one clock late", int'(statusByte), 'h47);
    chk("R2 reserved bit zero", int'(statusByte[3]), 0);
    vmBusyIn = 1'b0; cbufFullIn = 1'b0; cmdBusyIn = 1'b0;
    @(negedge clk);

    pulse(0);
    chk("R9 interrupt set", int'(statusByte), 'h60);
    pulse(1);
    chk("R10 memory full set", int'(statusByte), 'h70);

    xfer(2, 8'h40, 8'h00, 8'h00);
    chk("R3 first status byte", int'(rxb[0]), 'h70);
    chk("R3 second status byte", int'(rxb[1]), 'h70);
    chk("R7 drive when up", oeSeen, 16);
    chk("R5 two strobes", bvQ.size(), 2);

    rdActive = 1'b1; rdByte = 8'hA5;
    xfer(3, 8'h40, 8'h00, 8'h00);
    chk("R4 first byte is status", int'(rxb[0]), 'h70);
    chk("R4 read byte one", int'(rxb[1]), 'hA5);
    chk("R4 read byte two", int'(rxb[2]), 'hA5);
    rdActive = 1'b0;

    xfer(1, 8'h46, 8'h00, 8'h00);
    chk("R9 interrupt-read clears", int'(statusByte), 'h50);

    xfer(1, 8'h12, 8'h00, 8'h00);
    chk("R11 power-down sets PD", int'(statusByte), 'h90);

    pulse(0);
    chk("R9 interrupt in PD", int'(statusByte), 'hB0);
    xfer(1, 8'h28, 8'h00, 8'h00);
    chk("R6 erase dropped in PD", bvQ.size(), 0);
    chk("R10 erase in PD no effect", int'(statusByte), 'hB0);
    xfer(1, 8'h46, 8'h00, 8'h00);
    chk("R6 interrupt-read passes in PD", bvQ.size(), 1);
    chk("R9 cleared while PD", int'(statusByte), 'h90);

    xfer(1, 8'h10, 8'h00, 8'h00);
    chk("R11 second power-up", int'(statusByte), 'h50);
    xfer(2, 8'h2A, 8'h01, 8'h00);
    chk("R10 chip erase clears", int'(statusByte), 'h40);
    chk("R5 erase strobes", bvQ.size(), 2);
    if (bvQ.size() == 2) begin
      chk("R5 opcode flagged first", int'(bvQ[0]), 'h12A);
      chk("R5 data not first", int'(bvQ[1]), 'h001);
    end

    xfer(3, 8'h55, 8'h33, 8'hC3);
    chk("R5 generic strobes", bvQ.size(), 3);
    if (bvQ.size() == 3) begin
      chk("R5 generic opcode", int'(bvQ[0]), 'h155);
      chk("R5 generic byte two", int'(bvQ[1]), 'h033);
      chk("R5 generic byte three", int'(bvQ[2]), 'h0C3);
    end

    repeat (4) @(negedge clk);
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule